// File: doc/BRIEF.md
# USB-C Port Fault Escalation Manager

This block supervises one USB-C source port. While the port is powered it compares each digital VBUS sample against programmable over- and under-voltage limits and takes in over-current, VCONN short and thermal or budget alarm indications. It answers with a graded response. A minor fault drops the port to the 5 V safe profile and logs the event. A thermal alarm derates the port without switching it off. A burst of minor faults, or one severe over-current, ends the session and locks the port off until the cable is removed and plugged in again.

VBUS samples come in on a valid/ready stream. The manager always accepts: `vbus_ready_o` is held high, so a producer never sees back-pressure, and a beat counts only in a cycle where `vbus_valid_i` is high. All other pins are plain levels sampled on each rising clock edge. The host reads sticky fault flags, the code of the latest cause, and saturating attach and fault counters. A single-cycle clear pulse resets the flags and the code.

Top module: `pfault_mgr`

## Requirements
- R1: After reset and while `attach_i` is low, `vbus_en_o`, `vconn_en_o`, `latched_o`, flags, code and counters are all zero. A rising attach powers the port (`vbus_en_o`=1) on the next edge and adds one to `attach_cnt_o`.
- R2: A VBUS beat is a fault only when `vbus_valid_i` is high: over-voltage if sample > `ov_lim_i`, under-voltage if sample < `uv_lim_i`. A sample equal to either limit is not a fault. `vbus_ready_o` is always 1.
- R3: A minor fault (over-voltage, under-voltage or `oc_minor_i`) sets `profile_o` to 2 (5 V safe) and adds one to `fault_cnt_o`. Profile encoding: 0 full, 1 derated, 2 safe 5 V.
- R4: A thermal alarm moves profile 0 to 1, leaves a lower profile unchanged, keeps VBUS on and never counts toward escalation.
- R5: When the minor-fault count inside the window reaches `esc_limit_i`, the port latches off on that edge: `vbus_en_o`=0 and `latched_o`=1.
- R6: Each minor fault restarts the window. After `win_len_i` further cycles with no minor fault, the count returns to zero, so faults spaced `win_len_i`+1 cycles apart never escalate.
- R7: `fast_off_o` is high combinationally in the same cycle that `oc_severe_i` is seen on a powered port. On the next edge the port latches off.
- R8: A latched port stays off while `attach_i` stays high. A detach followed by a new attach restores VBUS with profile 0.
- R9: A VCONN short clears `vconn_en_o` on the next edge and leaves `vbus_en_o` high. VCONN returns on the next attach.
- R10: `flags_o` bits are sticky until a `host_clr_i` pulse: bit0 over-voltage, bit1 under-voltage, bit2 over-current, bit3 VCONN short, bit4 thermal. The clear does not touch the counters.
- R11: `code_o` holds the latest cause: 1 over-voltage, 2 under-voltage, 3 over-current, 4 VCONN short, 5 thermal, 0 none. When causes coincide, the priority is 3, 1, 2, 4, 5.
- R12: `attach_cnt_o` and `fault_cnt_o` stop at their all-ones value and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attach_i | input | 1 | Debounced cable-attached level |
| vbus_valid_i | input | 1 | VBUS sample valid |
| vbus_ready_o | output | 1 | Always high; samples never stall |
| vbus_mv_i | input | VW | VBUS sample |
| ov_lim_i | input | VW | Over-voltage limit |
| uv_lim_i | input | VW | Under-voltage limit |
| oc_minor_i | input | 1 | Minor over-current alarm |
| oc_severe_i | input | 1 | Severe over-current alarm |
| vconn_short_i | input | 1 | VCONN short indication |
| therm_alarm_i | input | 1 | Thermal or power-budget alarm |
| esc_limit_i | input | EW | Minor faults in a window that latch the port |
| win_len_i | input | WW | Window length in cycles (at least 1) |
| host_clr_i | input | 1 | Clears sticky flags and code |
| vbus_en_o | output | 1 | VBUS enable to the power path |
| vconn_en_o | output | 1 | VCONN enable |
| fast_off_o | output | 1 | Same-cycle cut request on severe over-current |
| latched_o | output | 1 | Port is locked off |
| profile_o | output | 2 | Allowed profile (0 full, 1 derated, 2 safe 5 V) |
| flags_o | output | 5 | Sticky fault flags |
| code_o | output | 3 | Latest fault cause |
| attach_cnt_o | output | CW | Saturating attach counter |
| fault_cnt_o | output | CW | Saturating fault-event counter |

## Verification
The bench places minor faults exactly `win_len_i`+1 cycles apart, which must never latch, and then exactly `win_len_i` cycles apart, which must latch on the third fault. A window that is off by one cycle fails one of these two runs. Samples equal to each limit, and out-of-range samples with valid low, catch a wrong comparison sense or an ungated stream. A long burst of thermal alarms drives the 4-bit fault counter past its maximum, so a counter that wraps reads a small value. The severe over-current test checks `fast_off_o` before the clock edge and the locked state after it, and a design that registers the cut arrives one cycle late.

// File: rtl/pfault_pkg.sv
package pfault_pkg;
  typedef enum logic [1:0] {PS_IDLE = 2'd0, PS_ON = 2'd1, PS_LOCK = 2'd2} port_st_t;
  typedef enum logic [1:0] {PROF_FULL = 2'd0, PROF_DERATE = 2'd1, PROF_SAFE5V = 2'd2} prof_t;

  localparam logic [2:0] CODE_NONE = 3'd0;
  localparam logic [2:0] CODE_OV   = 3'd1;
  localparam logic [2:0] CODE_UV   = 3'd2;
  localparam logic [2:0] CODE_OC   = 3'd3;
  localparam logic [2:0] CODE_VC   = 3'd4;
  localparam logic [2:0] CODE_TH   = 3'd5;

  // first member is the MSB: ov lands on bit0
  typedef struct packed {
    logic th;
    logic vc;
    logic oc;
    logic uv;
    logic ov;
  } hit_t;
endpackage

// File: rtl/pfault_detect.sv
module pfault_detect
  import pfault_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic          active_i,
  input  logic          vbus_valid_i,
  input  logic [VW-1:0] vbus_mv_i,
  input  logic [VW-1:0] ov_lim_i,
  input  logic [VW-1:0] uv_lim_i,
  input  logic          oc_minor_i,
  input  logic          oc_severe_i,
  input  logic          vconn_short_i,
  input  logic          therm_i,
  output hit_t          hits_o,
  output logic          minor_o,
  output logic          severe_o,
  output logic          any_o,
  output logic [2:0]    code_o
);
  logic over_v, under_v;

  assign over_v  = vbus_valid_i && (vbus_mv_i > ov_lim_i);
  assign under_v = vbus_valid_i && (vbus_mv_i < uv_lim_i);

  always_comb begin
    hits_o.ov = active_i && over_v;
    hits_o.uv = active_i && under_v;
    hits_o.oc = active_i && (oc_minor_i || oc_severe_i);
    hits_o.vc = active_i && vconn_short_i;
    hits_o.th = active_i && therm_i;
  end

  assign severe_o = active_i && oc_severe_i;
  assign minor_o  = hits_o.ov || hits_o.uv || (active_i && oc_minor_i);
  assign any_o    = |hits_o;

  always_comb begin
    if (hits_o.oc)      code_o = CODE_OC;
    else if (hits_o.ov) code_o = CODE_OV;
    else if (hits_o.uv) code_o = CODE_UV;
    else if (hits_o.vc) code_o = CODE_VC;
    else if (hits_o.th) code_o = CODE_TH;
    else                code_o = CODE_NONE;
  end
endmodule

// File: rtl/pfault_escalate.sv
module pfault_escalate
  import pfault_pkg::*;
#(
  parameter int WW = 16,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          attach_i,
  input  logic          minor_i,
  input  logic          severe_i,
  input  logic          therm_i,
  input  logic          vc_i,
  input  logic [EW-1:0] esc_limit_i,
  input  logic [WW-1:0] win_len_i,
  output port_st_t      st_o,
  output logic          enter_on_o,
  output logic          fast_off_o,
  output logic          vconn_en_o,
  output prof_t         prof_o
);
  localparam logic [EW-1:0] MCNT_MAX = {EW{1'b1}};

  port_st_t      st;
  prof_t         prof;
  logic [EW-1:0] mcnt, mcnt_inc;
  logic [WW-1:0] wcnt;
  logic          vc_off;

  assign mcnt_inc   = (mcnt == MCNT_MAX) ? mcnt : mcnt + 1'b1;
  assign enter_on_o = (st == PS_IDLE) && attach_i;
  assign fast_off_o = (st == PS_ON) && severe_i;
  assign vconn_en_o = (st == PS_ON) && !vc_off;
  assign st_o       = st;
  assign prof_o     = prof;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= PS_IDLE;
      prof   <= PROF_FULL;
      mcnt   <= '0;
      wcnt   <= '0;
      vc_off <= 1'b0;
    end else begin
      case (st)
        PS_IDLE: if (attach_i) begin
          st     <= PS_ON;
          prof   <= PROF_FULL;
          mcnt   <= '0;
          wcnt   <= '0;
          vc_off <= 1'b0;
        end
        PS_ON: begin
          if (!attach_i) begin
            st <= PS_IDLE;
          end else begin
            if (vc_i) vc_off <= 1'b1;
            if (minor_i) prof <= PROF_SAFE5V;
            else if (therm_i && prof == PROF_FULL) prof <= PROF_DERATE;
            if (severe_i) begin
              st <= PS_LOCK;
            end else if (minor_i) begin
              if (mcnt_inc >= esc_limit_i) st <= PS_LOCK;
              mcnt <= mcnt_inc;
              wcnt <= '0;
            end else if (mcnt != '0) begin
              if (wcnt == win_len_i - 1'b1) begin
                mcnt <= '0;
                wcnt <= '0;
              end else begin
                wcnt <= wcnt + 1'b1;
              end
            end
          end
        end
        default: if (!attach_i) st <= PS_IDLE;
      endcase
    end
  end

  // R7
  severe_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ON && attach_i && severe_i) |=> (st == PS_LOCK));
  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_LOCK && attach_i) |=> (st == PS_LOCK));
  // R9
  vconn_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ON && attach_i && vc_i && !severe_i && !minor_i) |=> (!vconn_en_o && st == PS_ON));
  // R4
  therm_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_ON && attach_i && therm_i && !minor_i && !severe_i) |=> (st == PS_ON && prof != PROF_FULL));
endmodule

// File: rtl/pfault_log.sv
module pfault_log
  import pfault_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hit_t          hits_i,
  input  logic          any_i,
  input  logic [2:0]    code_i,
  input  logic          enter_on_i,
  input  logic          host_clr_i,
  output logic [4:0]    flags_o,
  output logic [2:0]    code_o,
  output logic [CW-1:0] attach_cnt_o,
  output logic [CW-1:0] fault_cnt_o
);
  localparam int            NFLAG  = $bits(hit_t);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [NFLAG-1:0] hv;
  assign hv = hits_i;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags_o[i] <= 1'b0;
      else if (hv[i])      flags_o[i] <= 1'b1;
      else if (host_clr_i) flags_o[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          code_o <= CODE_NONE;
    else if (any_i)      code_o <= code_i;
    else if (host_clr_i) code_o <= CODE_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attach_cnt_o <= '0;
      fault_cnt_o  <= '0;
    end else begin
      if (enter_on_i && attach_cnt_o != CNT_MAX) attach_cnt_o <= attach_cnt_o + 1'b1;
      if (any_i && fault_cnt_o != CNT_MAX)       fault_cnt_o  <= fault_cnt_o + 1'b1;
    end
  end

  // R12
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_cnt_o == CNT_MAX) |=> (fault_cnt_o == CNT_MAX));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/pfault_mgr.sv
module pfault_mgr
  import pfault_pkg::*;
#(
  parameter int VW = 16,
  parameter int CW = 8,
  parameter int WW = 16,
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          attach_i,
  input  logic          vbus_valid_i,
  output logic          vbus_ready_o,
  input  logic [VW-1:0] vbus_mv_i,
  input  logic [VW-1:0] ov_lim_i,
  input  logic [VW-1:0] uv_lim_i,
  input  logic          oc_minor_i,
  input  logic          oc_severe_i,
  input  logic          vconn_short_i,
  input  logic          therm_alarm_i,
  input  logic [EW-1:0] esc_limit_i,
  input  logic [WW-1:0] win_len_i,
  input  logic          host_clr_i,
  output logic          vbus_en_o,
  output logic          vconn_en_o,
  output logic          fast_off_o,
  output logic          latched_o,
  output logic [1:0]    profile_o,
  output logic [4:0]    flags_o,
  output logic [2:0]    code_o,
  output logic [CW-1:0] attach_cnt_o,
  output logic [CW-1:0] fault_cnt_o
);
  port_st_t   st;
  prof_t      prof;
  hit_t       hits;
  logic       minor, severe, any_hit, enter_on, active;
  logic [2:0] cause;

  assign vbus_ready_o = 1'b1;
  assign active       = (st == PS_ON) && attach_i;
  assign vbus_en_o    = (st == PS_ON);
  assign latched_o    = (st == PS_LOCK);
  assign profile_o    = prof;

  pfault_detect #(.VW(VW)) u_det (
    .active_i(active), .vbus_valid_i(vbus_valid_i), .vbus_mv_i(vbus_mv_i),
    .ov_lim_i(ov_lim_i), .uv_lim_i(uv_lim_i), .oc_minor_i(oc_minor_i),
    .oc_severe_i(oc_severe_i), .vconn_short_i(vconn_short_i), .therm_i(therm_alarm_i),
    .hits_o(hits), .minor_o(minor), .severe_o(severe), .any_o(any_hit), .code_o(cause)
  );

  pfault_escalate #(.WW(WW), .EW(EW)) u_esc (
    .clk(clk), .rst_n(rst_n), .attach_i(attach_i), .minor_i(minor),
    .severe_i(severe), .therm_i(hits.th), .vc_i(hits.vc),
    .esc_limit_i(esc_limit_i), .win_len_i(win_len_i), .st_o(st),
    .enter_on_o(enter_on), .fast_off_o(fast_off_o), .vconn_en_o(vconn_en_o),
    .prof_o(prof)
  );

  pfault_log #(.CW(CW)) u_log (
    .clk(clk), .rst_n(rst_n), .hits_i(hits), .any_i(any_hit), .code_i(cause),
    .enter_on_i(enter_on), .host_clr_i(host_clr_i), .flags_o(flags_o),
    .code_o(code_o), .attach_cnt_o(attach_cnt_o), .fault_cnt_o(fault_cnt_o)
  );

  // R1
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !attach_i |=> !vbus_en_o);
endmodule

// File: tb/pfault_mgr_test.sv
`timescale 1ns/1ps
module pfault_mgr_test;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n, attach, vvalid, om, os, vc, th, hclr;
  logic [15:0] vbus, ovl, uvl;
  logic [3:0]  esc;
  logic [7:0]  win;
  logic        vready, ven, vcen, foff, latched;
  logic [1:0]  prof;
  logic [4:0]  flags;
  logic [2:0]  code;
  logic [3:0]  acnt, fcnt;
  int checks = 0, fails = 0;

  pfault_mgr #(.VW(16), .CW(4), .WW(8), .EW(4)) uut (
    .clk(clk), .rst_n(rst_n), .attach_i(attach), .vbus_valid_i(vvalid),
    .vbus_ready_o(vready), .vbus_mv_i(vbus), .ov_lim_i(ovl), .uv_lim_i(uvl),
    .oc_minor_i(om), .oc_severe_i(os), .vconn_short_i(vc), .therm_alarm_i(th),
    .esc_limit_i(esc), .win_len_i(win), .host_clr_i(hclr), .vbus_en_o(ven),
    .vconn_en_o(vcen), .fast_off_o(foff), .latched_o(latched), .profile_o(prof),
    .flags_o(flags), .code_o(code), .attach_cnt_o(acnt), .fault_cnt_o(fcnt)
  );

  // {attach, valid, oc_minor, oc_severe, vconn, therm, exp_en, exp_prof[2], exp_code[3], vbus[16]}
  localparam logic [27:0] VEC [0:11] = '{
    {6'b100000, 1'b1, 2'd0, 3'd0, 16'd5000},
    {6'b110000, 1'b1, 2'd0, 3'd0, 16'd5500},
    {6'b100001, 1'b1, 2'd1, 3'd5, 16'd5000},
    {6'b100000, 1'b1, 2'd1, 3'd5, 16'd9000},
    {6'b110000, 1'b1, 2'd2, 3'd1, 16'd6000},
    {6'b110000, 1'b1, 2'd2, 3'd1, 16'd4500},
    {6'b110000, 1'b1, 2'd2, 3'd2, 16'd4000},
    {6'b100010, 1'b1, 2'd2, 3'd4, 16'd5000},
    {6'b101000, 1'b0, 2'd2, 3'd3, 16'd5000},
    {6'b100000, 1'b0, 2'd2, 3'd3, 16'd5000},
    {6'b000000, 1'b0, 2'd2, 3'd3, 16'd5000},
    {6'b100000, 1'b1, 2'd0, 3'd3, 16'd5000}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic v, input logic [15:0] mv,
                       input logic m, input logic s, input logic c, input logic t);
    @(negedge clk);
    attach = a; vvalid = v; vbus = mv; om = m; os = s; vc = c; th = t; hclr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin drive(1, 0, 16'd5000, 0, 0, 0, 0); step(); end
  endtask

  task automatic minor_pulse();
    drive(1, 0, 16'd5000, 1, 0, 0, 0); step();
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 0; attach = 0; vvalid = 0; vbus = 16'd5000; om = 0; os = 0; vc = 0; th = 0;
    hclr = 0; ovl = 16'd5500; uvl = 16'd4500; esc = 4'd3; win = 8'd8;
    repeat (3) @(posedge clk); #1;
    // R1 reset state
    chk("R1 vbus_en", ven, 0); chk("R1 vconn_en", vcen, 0); chk("R1 latched", latched, 0);
    chk("R1 flags", flags, 0); chk("R1 code", code, 0); chk("R1 counters", acnt + fcnt, 0);
    chk("R2 ready", vready, 1);
    @(negedge clk); rst_n = 1;
    step();
    chk("R1 idle without attach", ven, 0);

    for (int i = 0; i < 12; i++) begin
      drive(VEC[i][27], VEC[i][26], VEC[i][15:0], VEC[i][25], VEC[i][24], VEC[i][23], VEC[i][22]);
      step();
      chk($sformatf("R3 row%0d vbus_en", i), ven, VEC[i][21]);
      chk($sformatf("R4 row%0d profile", i), prof, VEC[i][20:19]);
      chk($sformatf("R11 row%0d code", i), code, VEC[i][18:16]);
      if (i == 7) begin
        chk("R9 vconn off", vcen, 0);
        chk("R9 vbus stays", ven, 1);
      end
      if (i == 8) chk("R5 latched", latched, 1);
    end
    chk("R9 vconn back after reattach", vcen, 1);
    chk("R1 attach count", acnt, 2);
    chk("R2 ignored beats not counted", fcnt, 5);
    chk("R10 flags all", flags, 5'b11111);

    // R10 host clear
    @(negedge clk); hclr = 1; step();
    chk("R10 flags cleared", flags, 0);
    chk("R10 code cleared", code, 0);
    chk("R10 counters kept", fcnt, 5);

    // R6 faults 9 apart never escalate
    for (int k = 0; k < 3; k++) begin minor_pulse(); idle(8); end
    chk("R6 spaced faults no latch", ven, 1);
    // R5 faults 8 apart escalate on the third
    minor_pulse(); idle(7); minor_pulse(); idle(7);
    chk("R5 not yet latched", ven, 1);
    minor_pulse();
    chk("R5 latch on limit", ven, 0);
    chk("R5 latched flag", latched, 1);

    // R8 detach then reattach
    idle(3);
    chk("R8 stays latched", ven, 0);
    drive(0, 0, 16'd5000, 0, 0, 0, 0); step();
    drive(1, 0, 16'd5000, 0, 0, 0, 0); step();
    chk("R8 restored", ven, 1);
    chk("R8 profile full", prof, 0);

    // R7 severe over-current
    drive(1, 0, 16'd5000, 0, 1, 0, 0); #0.5;
    chk("R7 fast_off same cycle", foff, 1);
    chk("R7 still enabled before edge", ven, 1);
    step();
    chk("R7 vbus cut", ven, 0);
    chk("R7 latched", latched, 1);
    chk("R11 severe code", code, 3);
    idle(2);
    chk("R7 no fast_off when latched", foff, 0);
    drive(0, 0, 16'd5000, 0, 0, 0, 0); step();
    drive(1, 0, 16'd5000, 0, 0, 0, 0); step();

    // R4 / R12 thermal burst saturates the counter
    for (int k = 0; k < 20; k++) begin drive(1, 0, 16'd5000, 0, 0, 0, 1); step(); end
    chk("R4 thermal keeps vbus", ven, 1);
    chk("R4 thermal derates", prof, 1);
    chk("R12 fault count saturates", fcnt, 15);
    chk("R1 attach count total", acnt, 4);
    drive(1, 1, 16'd5501, 0, 0, 0, 0); step();
    chk("R2 over-voltage by one", code, 1);
    chk("R3 fallback after minor", prof, 2);
    summary();
  end
endmodule